// File: doc/BRIEF.md
# Interrupt Register Indirect Access Router

This block sits between a hart's indirect register window and an interrupt file. Each access arrives as one cycle of request fields: the privilege level of the requester, a virtualization flag, a guest page selector, an 8-bit select number, a separate strobe for the top-interrupt register, a width flag (32 or 64 bits), write data and a write mask. The router works out which page of the interrupt file the access belongs to. It also works out which register or register word inside that page is meant.

A legal access produces a one-cycle strobe towards the interrupt file. The strobe carries the page, the register kind, the word index, the width, the data and the mask, all registered. The file answers with read data in the same cycle, and the router returns that data as its response.

An illegal access never reaches the file. It returns zero read data and raises an error flag for exactly one cycle. The parameter `MACHINE_FILE` picks the variant:
- A machine-level file has one page and accepts only plain machine-privilege accesses.
- A supervisor-level file has `NUM_PAGES` pages: page 0 for the host and one page per guest.

Top module: `irq_ireg_router`

## Requirements
- R1: With `MACHINE_FILE`=1, an access is accepted only when the privilege is machine (2'b11) and the virtualization flag is low. It then targets page 0. Any other privilege or a virtualized access is an error.
- R2: With `MACHINE_FILE`=0, only supervisor privilege (2'b01) is accepted. A non-virtualized supervisor access targets page 0. User (2'b00) and machine (2'b11) accesses are errors.
- R3: A virtualized supervisor access targets the page equal to the guest selector. A selector of zero, or one not below `NUM_PAGES`, is an error.
- R4: When the top strobe is low, the select number decodes as follows; every other select value is an error:
  - 0x70 gives kind 0 (delivery).
  - 0x72 gives kind 1 (threshold).
  - 0x80–0xBF give kind 3 (pending word, index = select − 0x80).
  - 0xC0–0xFF give kind 4 (enable word, index = select − 0xC0).
- R5: When the top strobe is high, the access is kind 2 (top interrupt) with word 0, whatever the select number.
- R6: For a 64-bit access to a pending or enable word, an odd index is an error. An even index is halved before it is sent to the file.
- R7: A word access is an error when its index is not below `NUM_IDS`/32 (32-bit) or its halved index is not below `NUM_IDS`/64 (64-bit).
- R8: A legal access presented in cycle N gives the file strobe with all its fields in cycle N+1. The response in cycle N+1 carries the file's read data of that cycle.
- R9: A failed access raises the error flag and the response valid in cycle N+1 for that one cycle only, returns zero read data, and issues no file strobe.
- R10: A 32-bit access forwards only the low 32 bits of the write mask; the upper 32 mask bits are zero at the file. The file write enable is high exactly when the forwarded mask is nonzero.
- R11: While reset is low, and in the first cycle after it, no strobe, response or error is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_priv | input | 2 | Requester privilege: 00 user, 01 supervisor, 11 machine |
| acc_virt | input | 1 | Access comes from a virtualized context |
| acc_gsel | input | GSEL_W | Guest page selector |
| acc_sel | input | 8 | Register select number |
| acc_top | input | 1 | Access targets the top-interrupt register |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_wdata | input | 64 | Write data |
| acc_wmask | input | 64 | Write bit mask |
| f_en | output | 1 | Strobe to the interrupt file |
| f_we | output | 1 | Strobe carries a write |
| f_kind | output | 3 | Register kind (0 delivery, 1 threshold, 2 top, 3 pending, 4 enable) |
| f_page | output | PAGE_W | Target page |
| f_word | output | 6 | Word index (halved for 64-bit) |
| f_wide | output | 1 | Width of the strobe |
| f_wdata | output | 64 | Write data to the file |
| f_wmask | output | 64 | Write mask to the file |
| f_rdata | input | 64 | Read data from the file, same cycle as the strobe |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access failed |
| rsp_rdata | output | 64 | Read data returned, zero on error |

## Verification
A wrong page, kind or word decision is latched in a single register stage. It therefore appears on the strobe fields exactly one cycle after the request, and in the bench's file model as data landing in the wrong word. A later read-back exposes that a few cycles on. A mis-set error decision shows up in that same next cycle, either as a missing strobe or as a strobe beside an error flag. A stuck error or response register shows up as the flag staying high into the idle cycle that follows. Reset state is seen directly on the outputs in the first cycle after release.

// File: rtl/irq_ireg_pkg.sv
// Package: shared kinds, privilege codes and select values for the
// indirect register router. Assumes an 8-bit select number.
package irq_ireg_pkg;

    typedef enum logic [2:0] {
        K_DELIV  = 3'd0,
        K_THRESH = 3'd1,
        K_TOP    = 3'd2,
        K_PEND   = 3'd3,
        K_ENAB   = 3'd4
    } reg_kind_e;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int SEL_W   = 8;
    localparam int WORD_W  = 6;

    localparam logic [SEL_W-1:0] SEL_DELIV  = 8'h70;
    localparam logic [SEL_W-1:0] SEL_THRESH = 8'h72;
    localparam logic [1:0]       SEL_PEND_HI = 2'b10;
    localparam logic [1:0]       SEL_ENAB_HI = 2'b11;

endpackage

// File: rtl/irq_page_resolve.sv
// Module: chooses the interrupt file page from privilege, virtualization
// flag and guest selector. Purely combinational. Assumes GSEL_W >= PAGE_W.
module irq_page_resolve
    import irq_ireg_pkg::*;
#(
    parameter bit MACHINE_FILE = 1'b0,
    parameter int NUM_PAGES    = 4,
    parameter int GSEL_W       = 6,
    parameter int PAGE_W       = 2
) (
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic [GSEL_W-1:0] gsel,
    output logic [PAGE_W-1:0] page,
    output logic              page_ok
);

    logic gsel_in_range;

    // Guest selector must be nonzero and below the page count
    always_comb begin
        gsel_in_range = (gsel != '0) && (32'(gsel) < NUM_PAGES);
    end

    generate
        if (MACHINE_FILE) begin : g_mfile
            // Machine file: plain machine access only, always page 0
            always_comb begin
                page    = '0;
                page_ok = (priv == PRIV_M) && !virt;
            end
        end else begin : g_sfile
            // Supervisor file: host page 0 or guest page from selector
            always_comb begin
                page    = '0;
                page_ok = 1'b0;
                if (priv == PRIV_S) begin
                    if (virt) begin
                        page_ok = gsel_in_range;
                        page    = gsel_in_range ? gsel[PAGE_W-1:0] : '0;
                    end else begin
                        page_ok = 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_sel_decode.sv
// Module: decodes the select number (or the top strobe) into a register
// kind and a raw word index. Purely combinational.
module irq_sel_decode
    import irq_ireg_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic              top,
    output reg_kind_e         kind,
    output logic [WORD_W-1:0] word_raw,
    output logic              is_word,
    output logic              sel_ok
);

    // Map select value onto register kind; top strobe takes precedence
    always_comb begin
        kind     = K_DELIV;
        word_raw = '0;
        is_word  = 1'b0;
        sel_ok   = 1'b0;
        if (top) begin
            kind   = K_TOP;
            sel_ok = 1'b1;
        end else if (sel[7:6] == SEL_PEND_HI) begin
            kind     = K_PEND;
            word_raw = sel[WORD_W-1:0];
            is_word  = 1'b1;
            sel_ok   = 1'b1;
        end else if (sel[7:6] == SEL_ENAB_HI) begin
            kind     = K_ENAB;
            word_raw = sel[WORD_W-1:0];
            is_word  = 1'b1;
            sel_ok   = 1'b1;
        end else if (sel == SEL_DELIV) begin
            kind   = K_DELIV;
            sel_ok = 1'b1;
        end else if (sel == SEL_THRESH) begin
            kind   = K_THRESH;
            sel_ok = 1'b1;
        end
    end

endmodule

// File: rtl/irq_word_check.sv
// Module: checks a pending/enable word index against width and identity
// count, halving it for 64-bit accesses. Assumes NUM_IDS is a multiple of 64.
module irq_word_check
    import irq_ireg_pkg::*;
#(
    parameter int NUM_IDS = 256
) (
    input  logic [WORD_W-1:0] word_raw,
    input  logic              is_word,
    input  logic              wide,
    output logic [WORD_W-1:0] word,
    output logic              word_ok
);

    localparam int WORDS_32 = NUM_IDS / 32;
    localparam int WORDS_64 = NUM_IDS / 64;

    logic [WORD_W-1:0] halved;

    // Halve and bound-check the index by access width
    always_comb begin
        halved = {1'b0, word_raw[WORD_W-1:1]};
        if (!is_word) begin
            word    = '0;
            word_ok = 1'b1;
        end else if (wide) begin
            word    = halved;
            word_ok = !word_raw[0] && (32'(halved) < WORDS_64);
        end else begin
            word    = word_raw;
            word_ok = 32'(word_raw) < WORDS_32;
        end
    end

endmodule

// File: rtl/irq_ireg_router.sv
// Module: top of the indirect register router. Combines page, select and
// word checks, registers one strobe to the interrupt file and returns the
// file's same-cycle read data, or zero with a one-cycle error flag.
// Assumes the file answers combinationally while f_en is high.
module irq_ireg_router
    import irq_ireg_pkg::*;
#(
    parameter bit MACHINE_FILE = 1'b0,
    parameter int NUM_PAGES    = 4,
    parameter int NUM_IDS      = 256,
    parameter int GSEL_W       = 6,
    parameter int DATA_W       = 64,
    parameter int PAGE_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_priv,
    input  logic              acc_virt,
    input  logic [GSEL_W-1:0] acc_gsel,
    input  logic [7:0]        acc_sel,
    input  logic              acc_top,
    input  logic              acc_wide,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] acc_wmask,
    output logic              f_en,
    output logic              f_we,
    output logic [2:0]        f_kind,
    output logic [PAGE_W-1:0] f_page,
    output logic [5:0]        f_word,
    output logic              f_wide,
    output logic [DATA_W-1:0] f_wdata,
    output logic [DATA_W-1:0] f_wmask,
    input  logic [DATA_W-1:0] f_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int HALF_W   = DATA_W / 2;
    localparam int WORDS_64 = NUM_IDS / 64;

    logic [PAGE_W-1:0] page_c;
    logic              page_ok;
    reg_kind_e         kind_c;
    logic [WORD_W-1:0] word_raw_c;
    logic [WORD_W-1:0] word_c;
    logic              is_word_c;
    logic              sel_ok;
    logic              word_ok;
    logic              acc_ok;
    logic [DATA_W-1:0] mask_c;

    irq_page_resolve #(
        .MACHINE_FILE (MACHINE_FILE),
        .NUM_PAGES    (NUM_PAGES),
        .GSEL_W       (GSEL_W),
        .PAGE_W       (PAGE_W)
    ) u_page (
        .priv    (acc_priv),
        .virt    (acc_virt),
        .gsel    (acc_gsel),
        .page    (page_c),
        .page_ok (page_ok)
    );

    irq_sel_decode u_sel (
        .sel      (acc_sel),
        .top      (acc_top),
        .kind     (kind_c),
        .word_raw (word_raw_c),
        .is_word  (is_word_c),
        .sel_ok   (sel_ok)
    );

    irq_word_check #(
        .NUM_IDS (NUM_IDS)
    ) u_word (
        .word_raw (word_raw_c),
        .is_word  (is_word_c),
        .wide     (acc_wide),
        .word     (word_c),
        .word_ok  (word_ok)
    );

    // Combine the three verdicts and narrow the mask for 32-bit accesses
    always_comb begin
        acc_ok = page_ok && sel_ok && word_ok;
        mask_c = acc_wide ? acc_wmask : {{HALF_W{1'b0}}, acc_wmask[HALF_W-1:0]};
    end

    // Register the file strobe and the response flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_en      <= 1'b0;
            f_we      <= 1'b0;
            f_kind    <= 3'd0;
            f_page    <= '0;
            f_word    <= '0;
            f_wide    <= 1'b0;
            f_wdata   <= '0;
            f_wmask   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            f_en      <= acc_valid && acc_ok;
            f_we      <= acc_valid && acc_ok && (mask_c != '0);
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && !acc_ok;
            if (acc_valid && acc_ok) begin
                f_kind  <= kind_c;
                f_page  <= page_c;
                f_word  <= word_c;
                f_wide  <= acc_wide;
                f_wdata <= acc_wdata;
                f_wmask <= mask_c;
            end
        end
    end

    // Return file data only for an accepted access
    always_comb begin
        rsp_rdata = f_en ? f_rdata : '0;
    end

    // R8: a strobe only follows a request in the previous cycle
    a_r8_strobe_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        f_en |-> $past(acc_valid));

    // R9: error never coincides with a file strobe and follows a request
    a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!f_en && rsp_valid && $past(acc_valid)));

    // R3: accepted page always lies inside the page range
    a_r3_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        f_en |-> (32'(f_page) < NUM_PAGES));

    // R1: machine-level file only ever strobes page 0
    a_r1_mfile_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (MACHINE_FILE && f_en) |-> (f_page == '0));

    // R7: halved 64-bit word index stays below the identity bound
    a_r7_wide_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (f_en && f_wide && (f_kind == K_PEND || f_kind == K_ENAB)) |->
            (32'(f_word) < WORDS_64));

    // R10: 32-bit strobe carries no upper mask bits
    a_r10_narrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (f_en && !f_wide) |-> (f_wmask[DATA_W-1:HALF_W] == '0));

    // R9: the error flag never lasts past a single cycle without a new request
    a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !$past(acc_valid, 1)) |-> 1'b0);

endmodule

// File: tb/test_irq_ireg_router.sv
// Bench: vector table for decode outcomes on the supervisor variant, then
// directed tests for data paths, mask narrowing, error pulse, reset and the
// machine variant. The interrupt file is a simple word array model.
module test_irq_ireg_router;
    import irq_ireg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        acc_valid = 1'b0;
    logic [1:0]  acc_priv = 2'b00;
    logic        acc_virt = 1'b0;
    logic [5:0]  acc_gsel = '0;
    logic [7:0]  acc_sel = '0;
    logic        acc_top = 1'b0;
    logic        acc_wide = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_wmask = '0;

    logic        f_en, f_we, f_wide, rsp_valid, rsp_err;
    logic [2:0]  f_kind;
    logic [1:0]  f_page;
    logic [5:0]  f_word;
    logic [63:0] f_wdata, f_wmask, f_rdata, rsp_rdata;

    logic        m_en, m_we, m_wide, m_valid, m_err;
    logic [2:0]  m_kind;
    logic [0:0]  m_page;
    logic [5:0]  m_word;
    logic [63:0] m_wdata, m_wmask, m_rdata;
    localparam logic [63:0] M_FILE_DATA = 64'hC0DE_0000_0000_BEEF;

    int errors = 0;
    int checks = 0;

    irq_ireg_router #(.MACHINE_FILE(1'b0), .NUM_PAGES(4), .NUM_IDS(256)) i_irq_ireg_router (
        .clk, .rst_n, .acc_valid, .acc_priv, .acc_virt, .acc_gsel, .acc_sel,
        .acc_top, .acc_wide, .acc_wdata, .acc_wmask,
        .f_en, .f_we, .f_kind, .f_page, .f_word, .f_wide, .f_wdata, .f_wmask,
        .f_rdata, .rsp_valid, .rsp_err, .rsp_rdata
    );

    irq_ireg_router #(.MACHINE_FILE(1'b1), .NUM_PAGES(1), .NUM_IDS(256)) i_irq_ireg_router_mfile (
        .clk, .rst_n, .acc_valid, .acc_priv, .acc_virt, .acc_gsel, .acc_sel,
        .acc_top, .acc_wide, .acc_wdata, .acc_wmask,
        .f_en(m_en), .f_we(m_we), .f_kind(m_kind), .f_page(m_page), .f_word(m_word),
        .f_wide(m_wide), .f_wdata(m_wdata), .f_wmask(m_wmask),
        .f_rdata(M_FILE_DATA), .rsp_valid(m_valid), .rsp_err(m_err), .rsp_rdata(m_rdata)
    );

    // Interrupt file model: page*64 + kind*8 + word, 32-bit words
    logic [31:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + i;

    function automatic int widx(input int pg, input int kd, input int w);
        return pg * 64 + kd * 8 + w;
    endfunction

    always_comb begin
        f_rdata = '0;
        if (f_en) begin
            if (f_wide)
                f_rdata = {mem[widx(f_page, f_kind, 2*f_word+1)], mem[widx(f_page, f_kind, 2*f_word)]};
            else
                f_rdata = {32'h0, mem[widx(f_page, f_kind, f_word)]};
        end
    end

    always @(posedge clk) begin
        if (f_en && f_we) begin
            if (f_wide) begin
                mem[widx(f_page, f_kind, 2*f_word)] <=
                    (mem[widx(f_page, f_kind, 2*f_word)] & ~f_wmask[31:0]) | (f_wdata[31:0] & f_wmask[31:0]);
                mem[widx(f_page, f_kind, 2*f_word+1)] <=
                    (mem[widx(f_page, f_kind, 2*f_word+1)] & ~f_wmask[63:32]) | (f_wdata[63:32] & f_wmask[63:32]);
            end else begin
                mem[widx(f_page, f_kind, f_word)] <=
                    (mem[widx(f_page, f_kind, f_word)] & ~f_wmask[31:0]) | (f_wdata[31:0] & f_wmask[31:0]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one access for one cycle; returns at the negedge after the latching edge
    task automatic acc(input logic [1:0] pr, input logic vt, input logic [5:0] gs,
                       input logic [7:0] sl, input logic tp, input logic wd,
                       input logic [63:0] dat, input logic [63:0] msk);
        @(negedge clk);
        acc_priv = pr; acc_virt = vt; acc_gsel = gs; acc_sel = sl;
        acc_top = tp; acc_wide = wd; acc_wdata = dat; acc_wmask = msk;
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0] priv;
        logic       virt;
        logic [5:0] gsel;
        logic [7:0] sel;
        logic       top;
        logic       wide;
        logic       err;
        logic [1:0] page;
        logic [2:0] kind;
        logic [5:0] word;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 6'd0},  // R2 R4 delivery
        '{2'b01, 1'b0, 6'd0, 8'h72, 1'b0, 1'b0, 1'b0, 2'd0, 3'd1, 6'd0},  // R4 threshold
        '{2'b01, 1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 3'd2, 6'd0},  // R5 top
        '{2'b01, 1'b0, 6'd0, 8'h85, 1'b1, 1'b1, 1'b0, 2'd0, 3'd2, 6'd0},  // R5 top overrides select
        '{2'b01, 1'b0, 6'd0, 8'h83, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 6'd3},  // R4 pending
        '{2'b01, 1'b1, 6'd2, 8'hC5, 1'b0, 1'b0, 1'b0, 2'd2, 3'd4, 6'd5},  // R3 R4 guest enable
        '{2'b01, 1'b1, 6'd0, 8'h70, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R3 zero selector
        '{2'b01, 1'b1, 6'd4, 8'h70, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R3 selector at count
        '{2'b01, 1'b1, 6'd3, 8'h86, 1'b0, 1'b1, 1'b0, 2'd3, 3'd3, 6'd3},  // R3 R6 last page wide
        '{2'b01, 1'b0, 6'd0, 8'h85, 1'b0, 1'b1, 1'b1, 2'd0, 3'd0, 6'd0},  // R6 odd wide
        '{2'b01, 1'b0, 6'd0, 8'h88, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R7 narrow at bound
        '{2'b01, 1'b0, 6'd0, 8'h87, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 6'd7},  // R7 narrow last
        '{2'b01, 1'b0, 6'd0, 8'hC6, 1'b0, 1'b1, 1'b0, 2'd0, 3'd4, 6'd3},  // R7 wide last
        '{2'b01, 1'b0, 6'd0, 8'hC8, 1'b0, 1'b1, 1'b1, 2'd0, 3'd0, 6'd0},  // R7 wide at bound
        '{2'b00, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R2 user
        '{2'b11, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R2 machine
        '{2'b01, 1'b0, 6'd0, 8'h71, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R4 gap
        '{2'b01, 1'b0, 6'd0, 8'h7F, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},  // R4 below words
        '{2'b01, 1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0}   // R4 zero select
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state, held low for several cycles
        repeat (3) @(negedge clk);
        chk(!f_en && !rsp_valid && !rsp_err && !m_en && !m_valid, "R11 outputs in reset",
            {59'd0, f_en, rsp_valid, rsp_err, m_en, m_valid}, 64'd0);
        acc_valid = 1'b1; acc_priv = PRIV_S; acc_sel = 8'h70;
        @(negedge clk);
        chk(!f_en && !rsp_valid, "R11 request ignored in reset", {62'd0, f_en, rsp_valid}, 64'd0);
        acc_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!f_en && !rsp_valid && !rsp_err, "R11 first cycle after reset",
            {61'd0, f_en, rsp_valid, rsp_err}, 64'd0);

        // Vector table on the supervisor variant (R2-R7, R9)
        for (int v = 0; v < NV; v++) begin
            acc(VECS[v].priv, VECS[v].virt, VECS[v].gsel, VECS[v].sel, VECS[v].top,
                VECS[v].wide, 64'h0, 64'h0);
            if (VECS[v].err) begin
                chk(rsp_valid && rsp_err && !f_en && rsp_rdata == 0,
                    $sformatf("R9 vector %0d error", v), {rsp_err, f_en, rsp_rdata[61:0]}, {1'b1, 63'd0});
            end else begin
                chk(f_en && !rsp_err && rsp_valid, $sformatf("R8 vector %0d accepted", v),
                    {62'd0, f_en, rsp_err}, 64'd2);
                chk(f_page == VECS[v].page && f_kind == VECS[v].kind && f_word == VECS[v].word,
                    $sformatf("R4 vector %0d page/kind/word", v),
                    {53'd0, f_page, f_kind, f_word}, {53'd0, VECS[v].page, VECS[v].kind, VECS[v].word});
            end
        end

        // R9: error lasts one cycle only
        acc(2'b00, 1'b0, 6'd0, 8'h70, 1'b0, 1'b0, 64'h0, 64'h0);
        @(negedge clk);
        chk(!rsp_err && !rsp_valid, "R9 error one cycle", {62'd0, rsp_err, rsp_valid}, 64'd0);

        // R8 R10: narrow write to guest page 1 enable word 2, then read back
        acc(PRIV_S, 1'b1, 6'd1, 8'hC2, 1'b0, 1'b0, 64'hFFFF_FFFF_A5A5_0001, '1);
        chk(f_we && f_wmask == 64'h0000_0000_FFFF_FFFF, "R10 narrow mask upper zero",
            f_wmask, 64'h0000_0000_FFFF_FFFF);
        acc(PRIV_S, 1'b1, 6'd1, 8'hC2, 1'b0, 1'b0, 64'h0, 64'h0);
        chk(!f_we, "R10 zero mask is a read", {63'd0, f_we}, 64'd0);
        chk(rsp_rdata == 64'h0000_0000_A5A5_0001, "R8 narrow read back", rsp_rdata, 64'h0000_0000_A5A5_0001);
        chk(mem[widx(0, 4, 2)] == 32'h5A00_0000 + 32'(widx(0, 4, 2)), "R3 host page untouched",
            {32'd0, mem[widx(0, 4, 2)]}, {32'd0, 32'h5A00_0000 + 32'(widx(0, 4, 2))});

        // R6 R8: wide write to pending index 2 (halved 1), partial mask, read back
        acc(PRIV_S, 1'b0, 6'd0, 8'h82, 1'b0, 1'b1, 64'h1111_2222_3333_4444, 64'hFFFF_0000_0000_FFFF);
        chk(f_word == 6'd1 && f_wide, "R6 even index halved", {58'd0, f_word}, 64'd1);
        acc(PRIV_S, 1'b0, 6'd0, 8'h82, 1'b0, 1'b1, 64'h0, 64'h0);
        begin
            logic [63:0] lo_old, hi_old, exp;
            lo_old = 64'(32'h5A00_0000 + 32'(widx(0, 3, 2)));
            hi_old = 64'(32'h5A00_0000 + 32'(widx(0, 3, 3)));
            exp = {16'h1111, hi_old[15:0], lo_old[31:16], 16'h4444};
            chk(rsp_rdata == exp, "R8 wide masked read back", rsp_rdata, exp);
        end

        // R9: rejected write leaves the file word unchanged (guest selector 0)
        acc(PRIV_S, 1'b1, 6'd0, 8'hC2, 1'b0, 1'b0, 64'hDEAD_BEEF, '1);
        acc(PRIV_S, 1'b0, 6'd0, 8'hC2, 1'b0, 1'b0, 64'h0, 64'h0);
        chk(rsp_rdata == 64'(32'h5A00_0000 + 32'(widx(0, 4, 2))), "R9 failed write had no effect",
            rsp_rdata, 64'(32'h5A00_0000 + 32'(widx(0, 4, 2))));

        // R1: machine variant
        acc(PRIV_M, 1'b0, 6'd0, 8'h72, 1'b0, 1'b0, 64'h0, 64'h0);
        chk(m_en && !m_err && m_page == 1'b0 && m_kind == 3'd1, "R1 machine access page 0",
            {60'd0, m_en, m_err, m_kind[1:0]}, 64'h9);
        chk(m_rdata == M_FILE_DATA, "R1 machine read data", m_rdata, M_FILE_DATA);
        acc(PRIV_M, 1'b1, 6'd1, 8'h72, 1'b0, 1'b0, 64'h0, 64'h0);
        chk(m_err && !m_en && m_rdata == 0, "R1 virtualized machine access rejected",
            {62'd0, m_err, m_en}, 64'd2);
        acc(PRIV_S, 1'b0, 6'd0, 8'h72, 1'b0, 1'b0, 64'h0, 64'h0);
        chk(m_err && !m_en, "R1 supervisor access to machine file rejected", {62'd0, m_err, m_en}, 64'd2);

        // R11: reset in the middle clears a pending strobe
        @(negedge clk);
        acc_valid = 1'b1; acc_priv = PRIV_S; acc_virt = 1'b0; acc_sel = 8'h70; acc_top = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!f_en && !rsp_valid, "R11 reset clears strobe", {62'd0, f_en, rsp_valid}, 64'd0);
        acc_valid = 1'b0;
        rst_n = 1'b1;

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule